// File: doc/BRIEF.md
# Display Timing Generator

This block produces raster timing for a video output from a bank of registers written over a simple word-addressed port. A single flat pixel counter runs from zero to the programmed frame period and restarts. A second counter tracks the pixel position inside the current line. Both are decoded into horizontal sync, vertical sync and data-enable, and each of the three outputs can be inverted on its own.

Vertical timing is programmed in pixel clocks counted from the start of the frame, not in lines. Software multiplies line numbers by the line period before it writes them. For example, the display window opens at (vsync lines + back-porch lines) x line period + skew and closes at (total lines - front-porch lines) x line period + skew - 1. Inside the display window the block can narrow the image to an active window, separately in each direction. Display pixels outside an enabled active window are replaced by a programmable border colour. A frame counter and a line counter can be read back, and an enable register starts and stops the raster.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset every register reads 0, the raster is stopped, hsync, vsync and de are low, and pix_out is 0.
- R2: Word addresses: 0 enable (bit 0), 1 line control, 2 frame period, 3 vsync width, 4 display horizontal, 5 display vertical start, 6 display vertical end, 7 active horizontal, 8 active vertical start, 9 active vertical end, 10 window config (2 bits), 11 polarity (3 bits), 12 border colour, 13 frame count, 14 line count. Writable registers read back what was written, masked to their width. Writes to 13 and 14 have no effect.
- R3: The line control register holds the line period in bits [31:16] and the hsync width in bits [15:0]. The line position restarts after period-1, and hsync is active while the position is below the width.
- R4: The frame period and the vsync width are in pixel clocks. The flat counter restarts after period-1, and vsync is active while the flat count is below the width.
- R5: The display horizontal register holds the end pixel in bits [31:16] and the start pixel in bits [15:0]. de is active when the line position lies within start..end and the flat count lies within the display vertical start..end, both bounds inclusive. Outside that window pix_out is 0.
- R6: Config bit 0 enables the active horizontal window (end in [31:16], start in [15:0], compared to the line position). Config bit 1 enables the active vertical window (compared to the flat count). Display pixels inside every enabled window pass pix_in; the other display pixels output the border colour.
- R7: Polarity bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de.
- R8: The frame count increments each time the flat counter restarts. The line count increments at each line restart and returns to 0 at each frame start.
- R9: With enable 0, the positions and the line count return to 0 and stay there, the frame count holds, each sync output sits at its polarity bit (inactive level), and pix_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pix_in | input | 24 | Source pixel |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_out | output | 24 | Pixel, border colour or 0 |

## Verification
The hardest case to reach is a border pixel that lies outside the active window in one direction but inside it in the other. The line-restart and frame-restart boundaries must land on the same clock as that pixel. The bench programs a small 10x6 raster, starts it from a known stopped state so that the flat count is known on every cycle, and compares every output against an independent model over two whole frames. It does this with the windows off, with both active windows on, and with all polarities inverted. A mid-frame stop then shows that the outputs fall to their inactive levels and that the line count clears while the frame count holds.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
   localparam logic [3:0] A_EN     = 4'd0;
   localparam logic [3:0] A_LINE   = 4'd1;
   localparam logic [3:0] A_FPER   = 4'd2;
   localparam logic [3:0] A_VSW    = 4'd3;
   localparam logic [3:0] A_DHOR   = 4'd4;
   localparam logic [3:0] A_DVS    = 4'd5;
   localparam logic [3:0] A_DVE    = 4'd6;
   localparam logic [3:0] A_AHOR   = 4'd7;
   localparam logic [3:0] A_AVS    = 4'd8;
   localparam logic [3:0] A_AVE    = 4'd9;
   localparam logic [3:0] A_CFG    = 4'd10;
   localparam logic [3:0] A_POL    = 4'd11;
   localparam logic [3:0] A_BORDER = 4'd12;
   localparam logic [3:0] A_FRAME  = 4'd13;
   localparam logic [3:0] A_LINECT = 4'd14;

   localparam int SYNC_N = 3;   // bit 0 hsync, bit 1 vsync, bit 2 de
   localparam int CFG_W  = 2;   // bit 0 active-h enable, bit 1 active-v enable
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
   import dtg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int COLOR_W = 24,
   parameter int FRM_W   = 32,
   parameter int LINE_W  = 16,
   localparam int HW     = DATA_W / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [3:0]         addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic [FRM_W-1:0]   frame_cnt,
   input  logic [LINE_W-1:0]  line_cnt,
   output logic               en,
   output logic [HW-1:0]      h_per,
   output logic [HW-1:0]      hs_w,
   output logic [DATA_W-1:0]  f_per,
   output logic [DATA_W-1:0]  vs_w,
   output logic [HW-1:0]      dh_start,
   output logic [HW-1:0]      dh_end,
   output logic [DATA_W-1:0]  dv_start,
   output logic [DATA_W-1:0]  dv_end,
   output logic [HW-1:0]      ah_start,
   output logic [HW-1:0]      ah_end,
   output logic [DATA_W-1:0]  av_start,
   output logic [DATA_W-1:0]  av_end,
   output logic [CFG_W-1:0]   win_cfg,
   output logic [SYNC_N-1:0]  pol,
   output logic [COLOR_W-1:0] border
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= 1'b0;   h_per <= '0;  hs_w <= '0;   f_per <= '0;  vs_w <= '0;
         dh_start <= '0; dh_end <= '0; dv_start <= '0; dv_end <= '0;
         ah_start <= '0; ah_end <= '0; av_start <= '0; av_end <= '0;
         win_cfg <= '0; pol <= '0; border <= '0;
      end else if (wr) begin
         unique case (addr)
            A_EN:     en <= wdata[0];
            A_LINE:   {h_per, hs_w} <= wdata;
            A_FPER:   f_per <= wdata;
            A_VSW:    vs_w <= wdata;
            A_DHOR:   {dh_end, dh_start} <= wdata;
            A_DVS:    dv_start <= wdata;
            A_DVE:    dv_end <= wdata;
            A_AHOR:   {ah_end, ah_start} <= wdata;
            A_AVS:    av_start <= wdata;
            A_AVE:    av_end <= wdata;
            A_CFG:    win_cfg <= wdata[CFG_W-1:0];
            A_POL:    pol <= wdata[SYNC_N-1:0];
            A_BORDER: border <= wdata[COLOR_W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      unique case (addr)
         A_EN:     rdata = DATA_W'(en);
         A_LINE:   rdata = {h_per, hs_w};
         A_FPER:   rdata = f_per;
         A_VSW:    rdata = vs_w;
         A_DHOR:   rdata = {dh_end, dh_start};
         A_DVS:    rdata = dv_start;
         A_DVE:    rdata = dv_end;
         A_AHOR:   rdata = {ah_end, ah_start};
         A_AVS:    rdata = av_start;
         A_AVE:    rdata = av_end;
         A_CFG:    rdata = DATA_W'(win_cfg);
         A_POL:    rdata = DATA_W'(pol);
         A_BORDER: rdata = DATA_W'(border);
         A_FRAME:  rdata = DATA_W'(frame_cnt);
         A_LINECT: rdata = DATA_W'(line_cnt);
         default:  rdata = '0;
      endcase
   end

   AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == A_EN) |=> en == $past(wdata[0]));   // R2
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters #(
   parameter int DATA_W = 32,
   parameter int FRM_W  = 32,
   parameter int LINE_W = 16,
   localparam int HW    = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [HW-1:0]     h_per,
   input  logic [DATA_W-1:0] f_per,
   output logic [HW-1:0]     hpos,
   output logic [DATA_W-1:0] flat,
   output logic [FRM_W-1:0]  frame_cnt,
   output logic [LINE_W-1:0] line_cnt
);
   logic h_last, f_last;

   assign h_last = ({1'b0, hpos} + 1'b1) >= {1'b0, h_per};
   assign f_last = ({1'b0, flat} + 1'b1) >= {1'b0, f_per};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hpos <= '0; flat <= '0; frame_cnt <= '0; line_cnt <= '0;
      end else if (!en) begin
         hpos <= '0; flat <= '0; line_cnt <= '0;
      end else if (f_last) begin
         hpos <= '0; flat <= '0; line_cnt <= '0;
         frame_cnt <= frame_cnt + 1'b1;
      end else begin
         flat <= flat + 1'b1;
         if (h_last) begin
            hpos     <= '0;
            line_cnt <= line_cnt + 1'b1;
         end else begin
            hpos <= hpos + 1'b1;
         end
      end
   end

   AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && f_last) |=> frame_cnt == FRM_W'($past(frame_cnt) + 1'b1));   // R8
   AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (en && f_last) |=> (line_cnt == '0 && flat == '0 && hpos == '0));   // R8
   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (flat == '0 && hpos == '0 && frame_cnt == $past(frame_cnt)));   // R9
endmodule

// File: rtl/dtg_decode.sv
module dtg_decode
   import dtg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int COLOR_W = 24,
   localparam int HW     = DATA_W / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [HW-1:0]      hpos,
   input  logic [DATA_W-1:0]  flat,
   input  logic [HW-1:0]      hs_w,
   input  logic [DATA_W-1:0]  vs_w,
   input  logic [HW-1:0]      dh_start,
   input  logic [HW-1:0]      dh_end,
   input  logic [DATA_W-1:0]  dv_start,
   input  logic [DATA_W-1:0]  dv_end,
   input  logic [HW-1:0]      ah_start,
   input  logic [HW-1:0]      ah_end,
   input  logic [DATA_W-1:0]  av_start,
   input  logic [DATA_W-1:0]  av_end,
   input  logic [CFG_W-1:0]   win_cfg,
   input  logic [SYNC_N-1:0]  pol,
   input  logic [COLOR_W-1:0] border,
   input  logic [COLOR_W-1:0] pix_in,
   output logic [SYNC_N-1:0]  sync_o,
   output logic [COLOR_W-1:0] pix_out
);
   logic in_disp, in_act_h, in_act_v;
   logic [SYNC_N-1:0] sync_raw;

   assign in_disp  = (hpos >= dh_start) && (hpos <= dh_end) &&
                     (flat >= dv_start) && (flat <= dv_end);
   assign in_act_h = !win_cfg[0] || ((hpos >= ah_start) && (hpos <= ah_end));
   assign in_act_v = !win_cfg[1] || ((flat >= av_start) && (flat <= av_end));

   assign sync_raw = en ? {in_disp, (flat < vs_w), (hpos < hs_w)} : '0;

   for (genvar i = 0; i < SYNC_N; i++) begin : g_pol
      assign sync_o[i] = sync_raw[i] ^ pol[i];
   end

   always_comb begin
      if (!en || !in_disp)           pix_out = '0;
      else if (in_act_h && in_act_v) pix_out = pix_in;
      else                           pix_out = border;
   end

   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> sync_o == pol);   // R9
   AST_BLANK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_o[2] == pol[2]) |-> pix_out == '0);   // R5
   AST_BORDER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_o[2] != pol[2] && win_cfg == '0) |-> pix_out == pix_in);   // R6
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
   import dtg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int COLOR_W = 24,
   parameter int FRM_W   = 32,
   parameter int LINE_W  = 16,
   localparam int HW     = DATA_W / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [3:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [COLOR_W-1:0] pix_in,
   output logic               hsync,
   output logic               vsync,
   output logic               de,
   output logic [COLOR_W-1:0] pix_out
);
   if (DATA_W % 2 != 0)  begin : g_chk_even  $error("DATA_W must be even");       end
   if (COLOR_W > DATA_W) begin : g_chk_color $error("COLOR_W exceeds DATA_W");    end
   if (FRM_W > DATA_W)   begin : g_chk_frm   $error("FRM_W exceeds DATA_W");      end
   if (LINE_W > DATA_W)  begin : g_chk_line  $error("LINE_W exceeds DATA_W");     end

   logic               en;
   logic [HW-1:0]      h_per, hs_w, dh_start, dh_end, ah_start, ah_end, hpos;
   logic [DATA_W-1:0]  f_per, vs_w, dv_start, dv_end, av_start, av_end, flat;
   logic [CFG_W-1:0]   win_cfg;
   logic [SYNC_N-1:0]  pol, sync_o;
   logic [COLOR_W-1:0] border;
   logic [FRM_W-1:0]   frame_cnt;
   logic [LINE_W-1:0]  line_cnt;

   dtg_regs #(.DATA_W(DATA_W), .COLOR_W(COLOR_W), .FRM_W(FRM_W), .LINE_W(LINE_W)) u_regs (
      .clk, .rst_n, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
      .frame_cnt, .line_cnt, .en, .h_per, .hs_w, .f_per, .vs_w,
      .dh_start, .dh_end, .dv_start, .dv_end, .ah_start, .ah_end,
      .av_start, .av_end, .win_cfg, .pol, .border
   );

   dtg_counters #(.DATA_W(DATA_W), .FRM_W(FRM_W), .LINE_W(LINE_W)) u_cnt (
      .clk, .rst_n, .en, .h_per, .f_per, .hpos, .flat, .frame_cnt, .line_cnt
   );

   dtg_decode #(.DATA_W(DATA_W), .COLOR_W(COLOR_W)) u_dec (
      .clk, .rst_n, .en, .hpos, .flat, .hs_w, .vs_w, .dh_start, .dh_end,
      .dv_start, .dv_end, .ah_start, .ah_end, .av_start, .av_end,
      .win_cfg, .pol, .border, .pix_in, .sync_o, .pix_out
   );

   assign hsync = sync_o[0];
   assign vsync = sync_o[1];
   assign de    = sync_o[2];

   AST_LINE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |=> line_cnt == '0);   // R9
endmodule

// File: tb/disp_timing_gen_tb_top.sv
`timescale 1ns/100ps
module disp_timing_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [23:0] pix_in = 24'h123456;
   logic        hsync, vsync, de;
   logic [23:0] pix_out;

   int n_run = 0;
   int n_fail = 0;

   localparam int HPER = 10, VLINES = 6, FPER = HPER * VLINES;
   localparam logic [23:0] PIX = 24'h123456, BORD = 24'hABCDEF;

   always #2.5 clk = ~clk;   // 200 MHz

   disp_timing_gen dut_i (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .pix_in, .hsync, .vsync, .de, .pix_out
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic program_raster();
      wr(4'd0, 32'd0);
      wr(4'd1, {16'(HPER), 16'd2});     // period 10, hsync width 2
      wr(4'd2, 32'(FPER));              // 60 pixel clocks per frame
      wr(4'd3, 32'd10);                 // vsync one line
      wr(4'd4, {16'd8, 16'd3});         // display h 3..8
      wr(4'd5, 32'd20);                 // (1+1)*10
      wr(4'd6, 32'd49);                 // (6-1)*10-1
      wr(4'd7, {16'd7, 16'd4});         // active h 4..7
      wr(4'd8, 32'd20);
      wr(4'd9, 32'd39);                 // 20 + 2*10 - 1
      wr(4'd12, 32'(BORD));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk(hsync == 0 && vsync == 0 && de == 0, "R1 sync idle", {hsync, vsync, de}, 0);
      chk(pix_out == 0, "R1 pixel idle", pix_out, 0);
      for (int a = 0; a < 15; a++) begin
         rd(4'(a), d);
         chk(d == 0, "R1 register reset", d, 0);
      end
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(4'd2, 32'hDEAD_BEEF); rd(4'd2, d); chk(d == 32'hDEAD_BEEF, "R2 frame period rw", d, 32'hDEAD_BEEF);
      wr(4'd4, 32'h1234_5678); rd(4'd4, d); chk(d == 32'h1234_5678, "R2 display h rw", d, 32'h1234_5678);
      wr(4'd10, 32'hFFFF_FFFF); rd(4'd10, d); chk(d == 32'h3, "R2 config mask", d, 32'h3);
      wr(4'd11, 32'hFFFF_FFFF); rd(4'd11, d); chk(d == 32'h7, "R2 polarity mask", d, 32'h7);
      wr(4'd12, 32'hFFFF_FFFF); rd(4'd12, d); chk(d == 32'h00FF_FFFF, "R2 border mask", d, 32'h00FF_FFFF);
      wr(4'd13, 32'h55); rd(4'd13, d); chk(d == 0, "R2 frame count read-only", d, 0);
      wr(4'd14, 32'h55); rd(4'd14, d); chk(d == 0, "R2 line count read-only", d, 0);
      wr(4'd10, 0); wr(4'd11, 0);
   endtask

   // sweep two frames from a stopped start, comparing against a model
   task automatic t_sweep(input bit hen, input bit ven, input logic [2:0] p, input string tag);
      wr(4'd0, 0);
      wr(4'd10, {30'd0, ven, hen});
      wr(4'd11, {29'd0, p});
      wr(4'd0, 1);
      for (int c = 0; c < 2 * FPER; c++) begin
         int k, hp;
         bit ehs, evs, disp, act;
         logic [23:0] epx;
         k = c % FPER; hp = k % HPER;
         ehs = (hp < 2) ^ p[0];
         evs = (k < 10) ^ p[1];
         disp = (hp >= 3 && hp <= 8 && k >= 20 && k <= 49);
         act = (!hen || (hp >= 4 && hp <= 7)) && (!ven || (k >= 20 && k <= 39));
         epx = !disp ? 24'h0 : (act ? PIX : BORD);
         chk(hsync == ehs, {tag, " R3 hsync"}, hsync, ehs);
         chk(vsync == evs, {tag, " R4 vsync"}, vsync, evs);
         chk(de == (disp ^ p[2]), {tag, " R5 de"}, de, disp ^ p[2]);
         chk(pix_out == epx, {tag, " R6 pixel"}, pix_out, epx);
         @(negedge clk);
      end
   endtask

   task automatic t_counters();
      logic [31:0] f0, f1, ln;
      wr(4'd0, 0);
      rd(4'd13, f0);
      wr(4'd0, 1);
      repeat (2 * FPER + 25) @(negedge clk);
      rd(4'd14, ln);
      rd(4'd13, f1);
      chk(ln == 2, "R8 line count mid-frame", ln, 2);
      chk(f1 == f0 + 2, "R8 frame count after two wraps", f1, f0 + 2);
      repeat (FPER - 25) @(negedge clk);
      rd(4'd14, ln);
      chk(ln == 0, "R8 line count zero at frame start", ln, 0);
   endtask

   task automatic t_disable();
      logic [31:0] f0, f1, ln;
      wr(4'd11, 32'd5);                 // hsync and de inverted
      wr(4'd0, 0);
      wr(4'd0, 1);
      repeat (33) @(negedge clk);       // flat = 35 after write returns, inside display
      rd(4'd13, f0);
      wr(4'd0, 0);
      for (int c = 0; c < 20; c++) begin
         chk({de, vsync, hsync} == 3'b101, "R9 sync at inactive level", {de, vsync, hsync}, 3'b101);
         chk(pix_out == 0, "R9 pixel zero while stopped", pix_out, 0);
         @(negedge clk);
      end
      rd(4'd14, ln);
      rd(4'd13, f1);
      chk(ln == 0, "R9 line count cleared", ln, 0);
      chk(f1 == f0, "R9 frame count held", f1, f0);
      wr(4'd11, 0);
   endtask

   initial begin
      fork
         begin
            repeat (4) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_regs();
            program_raster();
            t_sweep(0, 0, 3'b000, "plain");
            t_sweep(1, 1, 3'b000, "border R6");
            t_sweep(1, 0, 3'b000, "hwin R6");
            t_sweep(0, 1, 3'b111, "inverted R7");
            t_counters();
            t_disable();
         end
         begin
            repeat (100000) @(posedge clk);
            chk(0, "watchdog", 0, 1);
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule